// File: doc/BRIEF.md
# FSK Tone Synthesiser with Baud Tick

This block produces the audio samples of a 300-baud, two-channel frequency-shift-keyed modem tone. It uses a direct digital synthesiser. An external rate strobe paces the block. On every strobe it registers one 8-bit sine amplitude and then advances a 16-bit phase accumulator by a tuning word. The tuning word depends on the channel (answer or originate) and on the data bit (mark or space). The accumulator keeps running across bit and channel changes, so every frequency switch is phase-continuous.

A second 16-bit accumulator gains a fixed fraction on every strobe. Each time it wraps, the block raises a one-cycle baud tick, which tells the data source to present its next bit. At a strobe rate near 31.37 kHz this gives an average of 300 ticks per second, with no integer divider.

The samples leave the block as a valid-qualified stream with no ready input. The strobe alone sets the rate, so one `sample_valid_o` pulse follows every strobe. The consumer, normally a PWM stage, must accept each sample in the cycle it is valid, because the block provides no back-pressure and no buffering.

Top module: `fsk_tone_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears both accumulators to 0 and drives `sample_o` to 128, `sample_valid_o` to 0 and `baud_tick_o` to 0. The first sample after reset is therefore 128, which is the table entry at index 0.
- R2: A strobe at edge k gives `sample_valid_o`=1 for exactly the cycle after edge k. In that cycle `sample_o` holds the table entry addressed by phase bits [15:10] as they stood before edge k's advance.
- R3: With `answer_i`=1, a strobe adds 4230 to the phase when `data_i`=0 (space) and 4648 when `data_i`=1 (mark), modulo 65536.
- R4: With `answer_i`=0, a strobe adds 2235 to the phase for a space and 2653 for a mark, modulo 65536.
- R5: Each strobe adds 627 to the baud accumulator, modulo 65536. When that addition wraps, `baud_tick_o` is 1 for exactly the cycle after the strobe. After N strobes from reset, exactly floor(N*627/65536) ticks have occurred, so the first tick follows the 105th strobe.
- R6: In cycles without a strobe, neither accumulator moves and `sample_o` holds its value. `sample_valid_o` and `baud_tick_o` are 0 in the cycle after such an edge.
- R7: The block samples `answer_i` and `data_i` only at strobe edges. Changes to them between strobes have no effect.
- R8: A change of bit or channel never resets the phase. The next increment continues from the accumulated value.
- R9: Table entry k (k = 0 to 63) equals round(128 + 127*sin(2*pi*k/64)). Every sample is therefore in the range 1 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Output-rate strobe, one cycle per sample |
| answer_i | input | 1 | Channel select: 1 = answer tones, 0 = originate tones |
| data_i | input | 1 | Data bit: 1 = mark, 0 = space |
| sample_o | output | 8 | Registered sine amplitude |
| sample_valid_o | output | 1 | One-cycle pulse after each strobe, with no ready |
| baud_tick_o | output | 1 | One-cycle pulse when the baud accumulator wraps |

## Verification
Assertions check several properties on every cycle. They check the reset values. They check that valid and tick pulses appear only after a strobe, and that a tick never appears without a valid. They check that the baud accumulator's top bit is clear in a tick cycle and that the phase does not move between strobes. They also check that the table index moves up on an advance without a wrap and does not move up on a wrap. Only the bench scenarios can show the exact tuning words, the table contents, the long-run tick count and the phase continuity across mode changes. The bench measures these against an independent phase model, including reset part-way through a run and inputs that toggle between strobes.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  localparam int PHASE_W = 16;
  localparam int IDX_W   = 6;
  localparam int AMP_W   = 8;

  localparam logic [PHASE_W-1:0] ANS_SPACE_INC = 16'd4230;
  localparam logic [PHASE_W-1:0] ANS_MARK_INC  = 16'd4648;
  localparam logic [PHASE_W-1:0] ORG_SPACE_INC = 16'd2235;
  localparam logic [PHASE_W-1:0] ORG_MARK_INC  = 16'd2653;
  localparam logic [PHASE_W-1:0] BAUD_INC      = 16'd627;

  // Rounded sine amplitude centred on mid-scale.
  function automatic int sine_entry(input int k, input int idx_w, input int amp_w);
    real pi, mid, ang;
    pi  = 3.14159265358979;
    mid = real'(1 << (amp_w - 1));
    ang = 2.0 * pi * real'(k) / real'(1 << idx_w);
    return $rtoi(mid + (mid - 1.0) * $sin(ang) + 0.5);
  endfunction
endpackage

// File: rtl/fsk_accum.sv
module fsk_accum #(
  parameter int W     = 16,
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [W-1:0]     inc_i,
  output logic [OUT_W-1:0] acc_hi_o,
  output logic             wrap_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum      = {1'b0, acc_q} + {1'b0, inc_i};
  assign wrap_o   = sum[W];
  assign acc_hi_o = acc_q[W-1 -: OUT_W];

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (en_i) acc_q <= sum[W-1:0];
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(acc_q)); // R6
endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom #(
  parameter int IDX_W = 6,
  parameter int AMP_W = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [AMP_W-1:0] amp_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [AMP_W-1:0] lut [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_lut
    localparam int VAL = fsk_pkg::sine_entry(k, IDX_W, AMP_W);
    assign lut[k] = AMP_W'(VAL);
  end

  assign amp_o = lut[idx_i];

  always_comb begin
    AST_AMP_NONZERO: assert (amp_o != '0); // R9
  end
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
  import fsk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic             answer_i,
  input  logic             data_i,
  output logic [AMP_W-1:0] sample_o,
  output logic             sample_valid_o,
  output logic             baud_tick_o
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

  logic [PHASE_W-1:0] tone_inc;
  logic [IDX_W-1:0]   phase_idx;
  logic               phase_wrap;
  logic               baud_msb;
  logic               baud_wrap;
  logic [AMP_W-1:0]   amp;

  // Tuning word chosen by channel and bit; only consumed when strobed.
  always_comb begin
    unique case ({answer_i, data_i})
      2'b11:   tone_inc = ANS_MARK_INC;
      2'b10:   tone_inc = ANS_SPACE_INC;
      2'b01:   tone_inc = ORG_MARK_INC;
      default: tone_inc = ORG_SPACE_INC;
    endcase
  end

  fsk_accum #(.W(PHASE_W), .OUT_W(IDX_W)) u_phase (
    .clk(clk), .rst(rst), .en_i(strobe_i), .inc_i(tone_inc),
    .acc_hi_o(phase_idx), .wrap_o(phase_wrap)
  );

  fsk_accum #(.W(PHASE_W), .OUT_W(1)) u_baud (
    .clk(clk), .rst(rst), .en_i(strobe_i), .inc_i(BAUD_INC),
    .acc_hi_o(baud_msb), .wrap_o(baud_wrap)
  );

  fsk_sine_rom #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_rom (
    .idx_i(phase_idx), .amp_o(amp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o       <= MID;
      sample_valid_o <= 1'b0;
      baud_tick_o    <= 1'b0;
    end else begin
      sample_valid_o <= strobe_i;
      baud_tick_o    <= strobe_i & baud_wrap;
      if (strobe_i) sample_o <= amp;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (sample_o == MID && !sample_valid_o && !baud_tick_o)); // R1
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    sample_valid_o |-> $past(strobe_i)); // R2
  AST_TICK_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    baud_tick_o |-> sample_valid_o); // R5
  AST_TICK_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
    baud_tick_o |-> !baud_msb); // R5
  AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> (!sample_valid_o && !baud_tick_o && $stable(sample_o))); // R6
  AST_PHASE_RISES: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && !phase_wrap) |=> phase_idx >= $past(phase_idx)); // R8
  AST_PHASE_WRAPS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && phase_wrap) |=> phase_idx <= $past(phase_idx)); // R8
endmodule

// File: tb/fsk_tone_gen_bench.sv
module fsk_tone_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_i = 1'b0;
  logic       answer_i = 1'b0;
  logic       data_i = 1'b0;
  logic [7:0] sample_o;
  logic       sample_valid_o;
  logic       baud_tick_o;

  int checks = 0;
  int errors = 0;
  int ph_m = 0;
  int baud_m = 0;
  int tick_total = 0;
  int strobes = 0;
  int first_tick = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fsk_tone_gen u_fsk_tone_gen (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .answer_i(answer_i),
    .data_i(data_i), .sample_o(sample_o), .sample_valid_o(sample_valid_o),
    .baud_tick_o(baud_tick_o)
  );

  // {answer, data, strobe count}
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{
    '{1, 0, 40}, '{1, 1, 40}, '{0, 0, 40},
    '{0, 1, 40}, '{1, 0, 300}, '{0, 1, 1600}
  };

  function automatic int sine_ref(input int k);
    real a;
    a = 2.0 * 3.14159265358979 * real'(k) / 64.0;
    return $rtoi(128.0 + 127.0 * $sin(a) + 0.5);
  endfunction

  function automatic int inc_ref(input int ans, input int b);
    if (ans != 0) return (b != 0) ? 4648 : 4230;
    return (b != 0) ? 2653 : 2235;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One strobe with checks of the outputs in the following cycle.
  task automatic strobe(input int ans, input int b, input int gap, input string req);
    int exp_s, nb, exp_t;
    exp_s  = sine_ref(ph_m >> 10);
    nb     = baud_m + 627;
    exp_t  = (nb > 65535) ? 1 : 0;
    baud_m = nb & 16'hFFFF;
    ph_m   = (ph_m + inc_ref(ans, b)) & 16'hFFFF;
    @(negedge clk);
    strobe_i = 1'b1; answer_i = ans[0]; data_i = b[0];
    @(negedge clk);
    strobe_i = 1'b0;
    strobes++;
    if (baud_tick_o) begin
      tick_total++;
      if (first_tick == 0) first_tick = strobes;
    end
    check(sample_o == exp_s[7:0], req, int'(sample_o), exp_s);
    check(sample_valid_o == 1'b1, "R2 valid", int'(sample_valid_o), 1);
    check(baud_tick_o == exp_t[0], "R5 tick", int'(baud_tick_o), exp_t);
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check(sample_o == 8'd128, "R1 sample", int'(sample_o), 128);
    check(!sample_valid_o && !baud_tick_o, "R1 flags",
          int'({sample_valid_o, baud_tick_o}), 0);
    rst = 1'b0;
    ph_m = 0; baud_m = 0; tick_total = 0; strobes = 0; first_tick = 0;
  endtask

  initial begin
    logic [7:0] held;
    int exp_ticks;
    do_reset();

    // R9: table contents over every index before the first wrap.
    for (int k = 0; k < 64; k++) begin
      check(sine_ref(k) >= 1 && sine_ref(k) <= 255, "R9 range", sine_ref(k), 128);
    end

    // R3 R4 R8: vector walk with mode/bit changes and no phase reset.
    for (int v = 0; v < NVEC; v++) begin
      for (int n = 0; n < VEC[v][2]; n++) begin
        strobe(VEC[v][0], VEC[v][1], n % 3, (VEC[v][0] != 0) ? "R3 sample" : "R4 sample");
      end
    end
    exp_ticks = (strobes * 627) / 65536;
    check(tick_total == exp_ticks, "R5 tick count", tick_total, exp_ticks);

    // R6: idle cycles hold everything.
    held = sample_o;
    repeat (4) @(negedge clk);
    check(sample_o == held, "R6 hold", int'(sample_o), int'(held));
    check(!sample_valid_o && !baud_tick_o, "R6 quiet",
          int'({sample_valid_o, baud_tick_o}), 0);

    // R7: toggle inputs between strobes; only strobe-time values count.
    for (int t = 0; t < 6; t++) begin
      @(negedge clk); answer_i = ~answer_i; data_i = ~data_i;
    end
    strobe(1, 1, 0, "R7 sample");
    for (int t = 0; t < 5; t++) begin
      @(negedge clk); data_i = ~data_i;
    end
    strobe(0, 0, 1, "R7 sample");
    strobe(1, 0, 0, "R8 sample");

    // R1 R5: reset part-way, then count to first wrap.
    do_reset();
    strobe(0, 0, 0, "R1 first sample");
    check(sample_o == 8'd128, "R1 index0", int'(sample_o), 128);
    for (int n = 1; n < 110; n++) strobe(n % 2, n % 3 == 0, 0, "R3 sample");
    check(first_tick == 105, "R5 first tick", first_tick, 105);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule